// File: doc/BRIEF.md
# Mantissa-Exponent Baud Rate Generator

This block turns a free-running reference clock enable into the strobes a serial receiver and transmitter need: a sample strobe at sixteen times the bit rate, and a bit-rate strobe at one sixteenth of that. The division ratio is not a plain binary count. It is held as a small mantissa N and a power-of-two exponent M, and the sample period is (N+1)·2^M reference enables. A 6-bit mantissa and a 4-bit exponent cover a very wide range of rates with only ten bits of setting.

Division happens in two stages. A linear counter divides the reference enables by N+1. A second counter divides the output of the first by 2^M, or passes it straight through when M is zero. A new setting presented on the divisor input is taken in only at the moment both stages wrap together, so the period that is running always completes with the setting it started with. Because settings with M = 0 are not dependable at fast reference clocks, the block raises a warning output whenever the setting in use has a zero exponent.

Top module: `me_baud_gen`

## Requirements
- R1: With the divisor word holding N in bits 5:0 and M in bits 9:6, the spacing between two sample strobes is exactly (N+1)·2^M reference enables.
- R2: With M = 0 the exponent stage passes every linear-stage wrap through, so the sample period is N+1 enables.
- R3: The all-zero setting (N = 0, M = 0) gives one sample strobe for every enabled cycle.
- R4: Nothing advances while the reference enable is low; a sample strobe is high only in the cycle after a clock edge at which the enable was high.
- R5: The bit strobe is high together with every 16th sample strobe counted from reset, and never without a sample strobe.
- R6: A new divisor word is taken in only when both stages wrap together; the period in progress completes with the old setting and the next period uses the new one, with no shortened period.
- R7: The warning output is high while the setting in use has M = 0 and low otherwise; it changes only when a setting is taken in.
- R8: During reset all three outputs are low; after reset the divisor word present at the first clock is taken in and the first sample strobe comes after exactly (N+1)·2^M enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | Reference clock enable; one count per high cycle |
| div_word_i | input | 10 | Divisor setting: N in bits 5:0, M in bits 9:6 |
| sample_tick_o | output | 1 | One-cycle strobe at 16 times the bit rate |
| bit_tick_o | output | 1 | One-cycle strobe at the bit rate |
| m_zero_warn_o | output | 1 | High while the setting in use has a zero exponent |

## Verification
The properties take for granted that the reference enable is a clean single-cycle-per-count qualifier and that the divisor word is a plain level which may change in any cycle. They also rely on the sample strobe being registered one stage behind the enable that completes a period. The stimulus drives the enable continuously, sparsely (every third cycle) and not at all, and changes the divisor word in the middle of a period, both to a shorter and to a longer ratio, so that the load-at-wrap rule is exercised while the strobes are running.

// File: rtl/me_baud_pkg.sv
`timescale 1ns/1ps
package me_baud_pkg;
   localparam int unsigned BG_MANT_W = 6;
   localparam int unsigned BG_EXP_W  = 4;
   localparam int unsigned BG_OVS    = 16;

   // width of a counter that can span 2^(2^w - 1) steps minus one
   function automatic int unsigned exp_span(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/me_baud_mant.sv
`timescale 1ns/1ps
module me_baud_mant #(
   parameter int unsigned W = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   input  logic [W-1:0] limit_i,
   output logic         wrap_o
);
   logic [W-1:0] cnt_q;

   assign wrap_o = step_i && (cnt_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (wrap_o) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/me_baud_exp.sv
`timescale 1ns/1ps
module me_baud_exp #(
   parameter int unsigned EXP_W = 4,
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             wrap_o
);
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] cnt_q;

   // mask holds the low exp_i bits; an empty mask makes the stage a pass-through
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask[i] = (int'(exp_i) > i);
   end

   assign wrap_o = step_i && ((cnt_q & mask) == mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (wrap_o) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/me_baud_ovs.sv
`timescale 1ns/1ps
module me_baud_ovs #(
   parameter int unsigned OVS = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic step_i,
   output logic wrap_o
);
   localparam int unsigned OVS_W = $clog2(OVS);

   logic [OVS_W-1:0] cnt_q;

   assign wrap_o = step_i && (cnt_q == OVS_W'(OVS - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/me_baud_gen.sv
`timescale 1ns/1ps
module me_baud_gen
   import me_baud_pkg::*;
#(
   parameter int unsigned MANT_W = BG_MANT_W,
   parameter int unsigned EXP_W  = BG_EXP_W,
   parameter int unsigned OVS    = BG_OVS,
   localparam int unsigned DIV_W = MANT_W + EXP_W,
   localparam int unsigned ECNT_W = exp_span(EXP_W)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_en_i,
   input  logic [DIV_W-1:0] div_word_i,
   output logic             sample_tick_o,
   output logic             bit_tick_o,
   output logic             m_zero_warn_o
);
   // elaboration-time parameter checks
   if (MANT_W < 1 || MANT_W > 16) begin : g_bad_mant
      $error("MANT_W out of range");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("EXP_W out of range");
   end
   if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 2");
   end

   logic              fresh_q;
   logic [MANT_W-1:0] n_q;
   logic [EXP_W-1:0]  m_q;
   logic [MANT_W-1:0] eff_n;
   logic [EXP_W-1:0]  eff_m;
   logic [MANT_W-1:0] new_n;
   logic [EXP_W-1:0]  new_m;
   logic              mant_wrap;
   logic              period_end;
   logic              bit_wrap;
   logic              load;
   logic              sample_q;
   logic              bit_q;
   logic              warn_q;

   assign new_n = div_word_i[MANT_W-1:0];
   assign new_m = div_word_i[DIV_W-1:MANT_W];

   // right after reset the input word is used directly until it is captured
   assign eff_n = fresh_q ? new_n : n_q;
   assign eff_m = fresh_q ? new_m : m_q;
   assign load  = fresh_q || period_end;

   me_baud_mant #(.W(MANT_W)) u_mant (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (ref_en_i),
      .limit_i (eff_n),
      .wrap_o  (mant_wrap)
   );

   me_baud_exp #(.EXP_W(EXP_W), .CNT_W(ECNT_W)) u_exp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (mant_wrap),
      .exp_i  (eff_m),
      .wrap_o (period_end)
   );

   me_baud_ovs #(.OVS(OVS)) u_ovs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (period_end),
      .wrap_o (bit_wrap)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fresh_q <= 1'b1;
         n_q     <= '0;
         m_q     <= '0;
         warn_q  <= 1'b0;
      end else begin
         fresh_q <= 1'b0;
         if (load) begin
            n_q    <= new_n;
            m_q    <= new_m;
            warn_q <= (new_m == '0);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sample_q <= 1'b0;
         bit_q    <= 1'b0;
      end else begin
         sample_q <= period_end;
         bit_q    <= bit_wrap;
      end
   end

   assign sample_tick_o = sample_q;
   assign bit_tick_o    = bit_q;
   assign m_zero_warn_o = warn_q;
endmodule

// File: rtl/me_baud_gen_chk.sv
`timescale 1ns/1ps
module me_baud_gen_chk #(
   parameter int unsigned MANT_W = 6,
   parameter int unsigned EXP_W  = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ref_en_i,
   input logic              sample_tick_o,
   input logic              bit_tick_o,
   input logic              m_zero_warn_o,
   input logic              fresh_i,
   input logic [MANT_W-1:0] n_i,
   input logic [EXP_W-1:0]  m_i
);
   AST_TICK_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_tick_o |-> $past(ref_en_i)); // R4

   AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_en_i |=> !sample_tick_o); // R4

   AST_BIT_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_tick_o |-> sample_tick_o); // R5

   AST_BIT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_tick_o |=> !bit_tick_o); // R5

   AST_ZERO_SETTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fresh_i && n_i == '0 && m_i == '0 && ref_en_i) |=> sample_tick_o); // R3

   AST_WARN_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(fresh_i) && !sample_tick_o) |-> $stable(m_zero_warn_o)); // R7

   AST_WARN_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fresh_i |-> (m_zero_warn_o == (m_i == '0))); // R7
endmodule

bind me_baud_gen me_baud_gen_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .ref_en_i      (ref_en_i),
   .sample_tick_o (sample_tick_o),
   .bit_tick_o    (bit_tick_o),
   .m_zero_warn_o (m_zero_warn_o),
   .fresh_i       (fresh_q),
   .n_i           (n_q),
   .m_i           (m_q)
);

// File: tb/test_me_baud_gen.sv
`timescale 1ns/1ps
module test_me_baud_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic [9:0] div_word = '0;
   logic       sample_tick;
   logic       bit_tick;
   logic       warn;

   int     checks = 0;
   int     fails = 0;
   longint en_total = 0;
   longint last_tick_en = 0;
   int     tick_cnt = 0;
   int     bit_cnt = 0;
   int     bit_err = 0;
   int     per_log [0:63];
   bit     done = 1'b0;

   always #5 clk = ~clk;

   me_baud_gen i_me_baud_gen (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .ref_en_i      (ref_en),
      .div_word_i    (div_word),
      .sample_tick_o (sample_tick),
      .bit_tick_o    (bit_tick),
      .m_zero_warn_o (warn)
   );

   // observer, away from the active edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (bit_tick && !sample_tick) bit_err++;
         if (sample_tick) begin
            if (tick_cnt < 64) per_log[tick_cnt] = int'(en_total - last_tick_en);
            last_tick_en = en_total;
            tick_cnt++;
            if (bit_tick != (tick_cnt % 16 == 0)) bit_err++;
            if (bit_tick) bit_cnt++;
         end
      end
   end

   function automatic logic [9:0] mk(input int n, input int m);
      return {4'(m), 6'(n)};
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [9:0] w);
      @(negedge clk);
      rst_n = 1'b0;
      ref_en = 1'b0;
      div_word = w;
      repeat (3) @(negedge clk);
      check(!sample_tick && !bit_tick && !warn, "R8 outputs low in reset",
            {sample_tick, bit_tick, warn}, 0);
      rst_n = 1'b1;
      en_total = 0;
      last_tick_en = 0;
      tick_cnt = 0;
      bit_cnt = 0;
      bit_err = 0;
      for (int i = 0; i < 64; i++) per_log[i] = 0;
   endtask

   // stride 1: enable every cycle; stride k: one enable every k cycles
   task automatic drive(input int cycles, input int stride);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         ref_en = (i % stride == 0);
         if (ref_en) en_total++;
      end
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         ref_en = 1'b0;
      end
   endtask

   task automatic t_reset_first;
      do_reset(mk(5, 3));
      drive(96, 1);
      idle(2);
      check(per_log[0] == 48, "R8 first period after reset", per_log[0], 48);
      check(per_log[1] == 48, "R1 N=5 M=3 period", per_log[1], 48);
   endtask

   task automatic t_period(input int n, input int m, input int periods, input string req);
      int exp_p;
      exp_p = (n + 1) << m;
      do_reset(mk(n, m));
      drive(exp_p * periods, 1);
      idle(2);
      check(tick_cnt == periods, req, tick_cnt, periods);
      for (int i = 0; i < periods; i++)
         check(per_log[i] == exp_p, req, per_log[i], exp_p);
   endtask

   task automatic t_zero;
      bit all_one;
      do_reset(mk(0, 0));
      drive(20, 1);
      idle(2);
      check(tick_cnt == 20, "R3 tick on each enable", tick_cnt, 20);
      all_one = 1'b1;
      for (int i = 0; i < 20; i++) if (per_log[i] != 1) all_one = 1'b0;
      check(all_one, "R3 period of one enable", all_one, 1);
   endtask

   task automatic t_sparse;
      int t0;
      do_reset(mk(2, 1));
      drive(54, 3);
      idle(2);
      check(tick_cnt == 3, "R4 sparse enable tick count", tick_cnt, 3);
      check(per_log[2] == 6, "R4 sparse enable period", per_log[2], 6);
      t0 = tick_cnt;
      idle(50);
      check(tick_cnt == t0, "R4 no tick without enable", tick_cnt, t0);
   endtask

   task automatic t_bits;
      do_reset(mk(1, 0));
      drive(80, 1);
      idle(2);
      check(tick_cnt == 40, "R5 sample ticks", tick_cnt, 40);
      check(bit_cnt == 2, "R5 bit ticks every 16th", bit_cnt, 2);
      check(bit_err == 0, "R5 bit tick alignment", bit_err, 0);
   endtask

   task automatic t_change;
      do_reset(mk(3, 2));
      drive(8, 1);
      div_word = mk(1, 1);
      drive(18, 1);
      div_word = mk(7, 1);
      drive(18, 1);
      idle(2);
      check(tick_cnt == 5, "R6 tick count across changes", tick_cnt, 5);
      check(per_log[0] == 16, "R6 old period completes", per_log[0], 16);
      check(per_log[1] == 4, "R6 new shorter period", per_log[1], 4);
      check(per_log[3] == 4, "R6 old period completes before longer", per_log[3], 4);
      check(per_log[4] == 16, "R6 new longer period", per_log[4], 16);
      check(bit_err == 0, "R5 bit alignment across changes", bit_err, 0);
   endtask

   task automatic t_warn;
      do_reset(mk(4, 0));
      idle(2);
      check(warn == 1'b1, "R7 warn with M=0", warn, 1);
      drive(2, 1);
      div_word = mk(4, 2);
      idle(1);
      check(warn == 1'b1, "R7 warn held until wrap", warn, 1);
      drive(3, 1);
      idle(2);
      check(warn == 1'b0, "R7 warn cleared after load", warn, 0);
      check(per_log[0] == 5, "R2 M=0 period", per_log[0], 5);
      drive(20, 1);
      idle(2);
      check(per_log[1] == 20, "R1 period after load", per_log[1], 20);
   endtask

   initial begin
      t_reset_first();
      t_period(5, 3, 3, "R1 N=5 M=3");
      t_period(63, 2, 2, "R1 N=63 M=2");
      t_period(0, 15, 1, "R1 N=0 M=15");
      t_period(10, 0, 3, "R2 N=10 M=0");
      t_zero();
      t_sparse();
      t_bits();
      t_change();
      t_warn();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule